// File: doc/BRIEF.md
# Punctured Convolutional Encoder

This block turns a serial stream of payload bits into a forward-error-corrected stream. It uses a constraint-length-7 mother code of rate 1/2. The two code bits of every input bit are sent out one after the other, first A and then B. A puncturing stage then removes bits by a periodic pattern, which gives code rates 1/2, 2/3 or 3/4. The whole datapath runs on one fast clock. A lower effective rate shows only as idle cycles on the output valid strobe, so no second clock is needed.

A frame opens with a one-cycle start pulse. On that pulse the block loads the code rate, clears the encoder history and restarts the puncture pattern. Payload bits enter through a ready/valid handshake, and the consumer can stall the output with its own ready signal. A one-cycle end pulse makes the block encode six zero bits behind the payload. These zero bits drive the encoder back to the all-zero state. They are punctured like payload bits, so the decoder sees a terminated trellis.

Top module: `punc_conv_enc`

## Requirements
- R1: Let x[n] be the current encoder input and x[n-k] the input k steps earlier in the same frame. Code bit A = x[n]^x[n-2]^x[n-3]^x[n-5]^x[n-6] (octal 133). Code bit B = x[n]^x[n-1]^x[n-2]^x[n-3]^x[n-6] (octal 171). Any input before the frame's first input counts as 0.
- R2: For each encoder input, its A bit (when kept) leaves before its B bit (when kept). The bits of one input leave before any bit of the next input.
- R3: rate_sel = 0 (rate 1/2) keeps every A and B bit. Code 3 behaves the same way.
- R4: rate_sel = 1 (rate 2/3) works in periods of two inputs. It keeps A and B of the first input and A of the second input, and drops B of the second input.
- R5: rate_sel = 2 (rate 3/4) works in periods of three inputs. It keeps A and B of the first input, keeps A and drops B of the second, and drops A and keeps B of the third.
- R6: rate_sel is sampled only in a cycle where frame_start is accepted. Changing it at any other time has no effect on the output.
- R7: An accepted frame_start clears the encoder history to zero and restarts the puncture period at its first input. frame_start is accepted only when no code bit is pending and no tail is in progress.
- R8: A frame_end pulse appends six zero inputs that are encoded and punctured like payload. While they are pending, in_ready is 0.
- R9: While out_valid is 1 and out_ready is 0, out_bit and out_valid hold on the next cycle. in_ready is 0 whenever out_valid is 1.
- R10: After reset, out_valid is 0, in_ready is 1, and rate 1/2 applies until the first accepted frame_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 2 | Code rate: 0 = 1/2, 1 = 2/3, 2 = 3/4 |
| frame_start | input | 1 | Frame opening pulse; samples rate_sel |
| frame_end | input | 1 | Request for the six zero tail inputs |
| in_valid | input | 1 | Payload bit offered |
| in_bit | input | 1 | Payload bit |
| in_ready | output | 1 | Block accepts a payload bit this cycle |
| out_valid | output | 1 | Coded bit available |
| out_bit | output | 1 | Coded bit |
| out_ready | input | 1 | Consumer takes the coded bit |

## Verification
The embedded properties assume that frame_start is raised only while the block is idle. They also assume that frame_end is raised at most once per frame, after the last payload bit and before the next frame_start. The bench keeps to both rules. It raises frame_start only once the expected output queue is empty and out_valid has been low. It issues exactly one frame_end per frame. Payload is offered with random gaps and drained under random back-pressure. Meanwhile rate_sel is deliberately changed in the middle of frames.

// File: rtl/pce_pkg.sv
package pce_pkg;
  localparam int unsigned CONSTR_LEN = 7;
  localparam logic [CONSTR_LEN-1:0] POLY_A = 7'o133;
  localparam logic [CONSTR_LEN-1:0] POLY_B = 7'o171;
  localparam logic [1:0] RATE_1_2 = 2'd0;
  localparam logic [1:0] RATE_2_3 = 2'd1;
  localparam logic [1:0] RATE_3_4 = 2'd2;
endpackage

// File: rtl/pce_conv_core.sv
module pce_conv_core #(
  parameter int unsigned K = 7,
  parameter logic [K-1:0] GEN_A = 7'o133,
  parameter logic [K-1:0] GEN_B = 7'o171
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic load,
  input  logic din,
  output logic code_a,
  output logic code_b
);
  localparam int unsigned HW = K - 1;
  localparam logic [2*K-1:0] GENS = {GEN_B, GEN_A};

  logic [HW-1:0] hist_q, hist_d;
  logic          hist_en;
  logic [1:0]    code;
  logic [K-1:0]  window;

  assign window = {din, hist_q};

  for (genvar g = 0; g < 2; g++) begin : g_gen
    assign code[g] = ^(window & GENS[g*K +: K]);
  end
  assign code_a = code[0];
  assign code_b = code[1];

  always_comb begin
    hist_en = clear | load;
    hist_d  = hist_q;
    if (clear)     hist_d = '0;
    else if (load) hist_d = {din, hist_q[HW-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hist_q <= '0;
    else if (hist_en) hist_q <= hist_d;
  end

  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (hist_q == '0));
  p_shift_newest_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear) |=> (hist_q[HW-1] == $past(din)));
endmodule

// File: rtl/pce_puncture.sv
module pce_puncture (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [1:0] rate_in,
  input  logic       advance,
  output logic       keep_a,
  output logic       keep_b
);
  import pce_pkg::*;

  logic [1:0] rate_q, rate_d;
  logic [1:0] phase_q, phase_d;
  logic [1:0] phase_last;
  logic       phase_en;

  always_comb begin
    case (rate_q)
      RATE_2_3: phase_last = 2'd1;
      RATE_3_4: phase_last = 2'd2;
      default:  phase_last = 2'd0;
    endcase
  end

  assign keep_a = !((rate_q == RATE_3_4) && (phase_q == 2'd2));
  assign keep_b = !(((rate_q == RATE_2_3) || (rate_q == RATE_3_4)) && (phase_q == 2'd1));

  always_comb begin
    phase_en = restart | advance;
    rate_d   = restart ? rate_in : rate_q;
    phase_d  = phase_q;
    if (restart)                    phase_d = 2'd0;
    else if (phase_q == phase_last) phase_d = 2'd0;
    else                            phase_d = phase_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q  <= RATE_1_2;
      phase_q <= 2'd0;
    end else begin
      if (restart)  rate_q  <= rate_d;
      if (phase_en) phase_q <= phase_d;
    end
  end

  p_phase_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= 2'd2);
  p_rate_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> $stable(rate_q));
  p_restart_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (phase_q == 2'd0));
endmodule

// File: rtl/pce_serializer.sv
module pce_serializer (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic a_in,
  input  logic b_in,
  input  logic keep_a_in,
  input  logic keep_b_in,
  input  logic out_ready,
  output logic full,
  output logic out_valid,
  output logic out_bit
);
  logic a_q, b_q, ka_q, kb_q, full_q;
  logic ka_d, kb_d, full_d;
  logic fire, pair_en, flag_en;

  assign fire      = full_q & out_ready;
  assign full      = full_q;
  assign out_valid = full_q;
  assign out_bit   = ka_q ? a_q : b_q;

  always_comb begin
    pair_en = load & ~full_q;
    flag_en = pair_en | fire;
    ka_d = ka_q;
    kb_d = kb_q;
    full_d = full_q;
    if (pair_en) begin
      ka_d = keep_a_in;
      kb_d = keep_b_in;
      full_d = keep_a_in | keep_b_in;
    end else if (fire) begin
      if (ka_q) begin
        ka_d = 1'b0;
        full_d = kb_q;
      end else begin
        kb_d = 1'b0;
        full_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
      ka_q <= 1'b0;
      kb_q <= 1'b0;
      full_q <= 1'b0;
    end else begin
      if (pair_en) begin
        a_q <= a_in;
        b_q <= b_in;
      end
      if (flag_en) begin
        ka_q <= ka_d;
        kb_q <= kb_d;
        full_q <= full_d;
      end
    end
  end

  p_hold_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));
  p_pending_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> (ka_q || kb_q));
  p_no_load_when_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !out_ready) |=> $stable(a_q) && $stable(b_q));
endmodule

// File: rtl/punc_conv_enc.sv
module punc_conv_enc #(
  parameter int unsigned K = pce_pkg::CONSTR_LEN,
  parameter logic [K-1:0] GEN_A = pce_pkg::POLY_A,
  parameter logic [K-1:0] GEN_B = pce_pkg::POLY_B
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rate_sel,
  input  logic       frame_start,
  input  logic       frame_end,
  input  logic       in_valid,
  input  logic       in_bit,
  output logic       in_ready,
  output logic       out_valid,
  output logic       out_bit,
  input  logic       out_ready
);
  localparam int unsigned TAIL_LEN = K - 1;
  localparam int unsigned TW = $clog2(TAIL_LEN + 1);
  localparam logic [TW-1:0] TAIL_INIT = TW'(TAIL_LEN);

  logic [TW-1:0] tail_q, tail_d;
  logic tail_en, tail_busy;
  logic full, idle, start_acc, end_acc;
  logic data_load, tail_load, load, din;
  logic code_a, code_b, keep_a, keep_b;

  assign tail_busy = (tail_q != '0);
  assign idle      = ~full & ~tail_busy;
  assign start_acc = frame_start & idle;
  assign end_acc   = frame_end & ~tail_busy & ~start_acc;
  assign in_ready  = ~full & ~tail_busy & ~frame_start & ~frame_end;
  assign data_load = in_valid & in_ready;
  assign tail_load = tail_busy & ~full;
  assign load      = data_load | tail_load;
  assign din       = data_load & in_bit;

  always_comb begin
    tail_en = end_acc | tail_load;
    tail_d  = tail_q;
    if (end_acc)        tail_d = TAIL_INIT;
    else if (tail_load) tail_d = tail_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tail_q <= '0;
    else if (tail_en) tail_q <= tail_d;
  end

  pce_conv_core #(.K(K), .GEN_A(GEN_A), .GEN_B(GEN_B)) i_core (
    .clk(clk), .rst_n(rst_n), .clear(start_acc), .load(load),
    .din(din), .code_a(code_a), .code_b(code_b));

  pce_puncture i_punc (
    .clk(clk), .rst_n(rst_n), .restart(start_acc), .rate_in(rate_sel),
    .advance(load), .keep_a(keep_a), .keep_b(keep_b));

  pce_serializer i_ser (
    .clk(clk), .rst_n(rst_n), .load(load), .a_in(code_a), .b_in(code_b),
    .keep_a_in(keep_a), .keep_b_in(keep_b), .out_ready(out_ready),
    .full(full), .out_valid(out_valid), .out_bit(out_bit));

  p_tail_blocks_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tail_busy |-> !in_ready);
  p_tail_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tail_load |-> !din);
  p_busy_blocks_input_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  p_tail_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    end_acc |=> (tail_q == TAIL_INIT));
endmodule

// File: tb/test_punc_conv_enc.sv
module test_punc_conv_enc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic frame_start = 1'b0, frame_end = 1'b0;
  logic in_valid = 1'b0, in_bit = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid, out_bit;

  int checks = 0, fails = 0;
  bit exp_q[$];
  int hist[1:6];
  int m_rate = 0, m_pos = 0;
  int lfsr = 32'h1ace5;
  string req = "R10";
  bit hold_pend = 1'b0, hold_bit = 1'b0, after_end = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  punc_conv_enc i_punc_conv_enc (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .frame_start(frame_start),
    .frame_end(frame_end), .in_valid(in_valid), .in_bit(in_bit),
    .in_ready(in_ready), .out_valid(out_valid), .out_bit(out_bit),
    .out_ready(out_ready));

  function automatic int rnd();
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'h80200003 : 0);
    return lfsr;
  endfunction

  task automatic check(input bit ok, input string r, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  function automatic void model_reset(input int r);
    for (int i = 1; i <= 6; i++) hist[i] = 0;
    m_rate = r;
    m_pos = 0;
  endfunction

  function automatic void model_in(input int x);
    int a, b, per;
    bit ka, kb;
    a = x ^ hist[2] ^ hist[3] ^ hist[5] ^ hist[6];
    b = x ^ hist[1] ^ hist[2] ^ hist[3] ^ hist[6];
    for (int i = 6; i > 1; i--) hist[i] = hist[i-1];
    hist[1] = x;
    per = (m_rate == 1) ? 2 : (m_rate == 2) ? 3 : 1;
    ka = 1'b1; kb = 1'b1;
    if (m_rate == 1 && m_pos == 1) kb = 1'b0;
    if (m_rate == 2 && m_pos == 1) kb = 1'b0;
    if (m_rate == 2 && m_pos == 2) ka = 1'b0;
    if (ka) exp_q.push_back(a[0]);
    if (kb) exp_q.push_back(b[0]);
    m_pos = (m_pos + 1) % per;
  endfunction

  task automatic step();
    #1;
    if (hold_pend) check(out_valid && out_bit == hold_bit, "R9", "held output", int'(out_bit), int'(hold_bit));
    if (out_valid) check(!in_ready, "R9", "in_ready while pending", int'(in_ready), 0);
    if (after_end) check(!in_ready, "R8", "in_ready during tail", int'(in_ready), 0);
    after_end = 1'b0;
    if (frame_start) model_reset(int'(rate_sel == 2'd3 ? 2'd0 : rate_sel));
    if (in_valid && in_ready) model_in(int'(in_bit));
    if (frame_end) begin
      for (int i = 0; i < 6; i++) model_in(0);
      after_end = 1'b1;
    end
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) check(1'b0, req, "unexpected output bit", int'(out_bit), -1);
      else check(out_bit == exp_q.pop_front(), req, "coded bit", int'(out_bit), -1);
    end
    hold_pend = out_valid && !out_ready;
    hold_bit = out_bit;
    @(negedge clk);
    frame_start = 1'b0;
    frame_end = 1'b0;
  endtask

  task automatic run_frame(input int r, input int nbits, input int gap, input int rdy, input bit do_start, input int fill);
    int sent = 0, guard = 0;
    if (do_start) begin
      rate_sel = 2'(r);
      frame_start = 1'b1;
      out_ready = 1'b1;
      step();
    end
    while (sent < nbits) begin
      in_valid = (rnd() % 100) >= gap;
      in_bit = (fill >= 0) ? fill[0] : rnd() % 2 == 1;
      out_ready = (rnd() % 100) >= rdy;
      if (sent == nbits / 2) rate_sel = 2'((r + 1) % 3);
      if (in_valid && in_ready) sent++;
      step();
    end
    in_valid = 1'b0;
    frame_end = 1'b1;
    step();
    while ((exp_q.size() > 0 || out_valid) && guard < 2000) begin
      out_ready = (rnd() % 100) >= rdy;
      guard++;
      step();
    end
    check(exp_q.size() == 0, req, "remaining expected bits", exp_q.size(), 0);
    out_ready = 1'b1;
    step();
    check(!out_valid, req, "idle after tail", int'(out_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    model_reset(0);
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid, "R10", "out_valid after reset", int'(out_valid), 0);
    check(in_ready, "R10", "in_ready after reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    req = "R10";      run_frame(0, 5, 0, 0, 1'b0, -1);
    req = "R1 R2 R3"; run_frame(0, 20, 30, 40, 1'b1, -1);
    req = "R3";       run_frame(3, 9, 10, 20, 1'b1, -1);
    req = "R4";       run_frame(1, 24, 25, 40, 1'b1, -1);
    req = "R5 R6";    run_frame(2, 30, 20, 50, 1'b1, -1);
    req = "R8";       run_frame(2, 7, 0, 0, 1'b1, -1);
    req = "R7";       run_frame(1, 11, 0, 30, 1'b1, 1);
    req = "R7";       run_frame(1, 11, 0, 30, 1'b1, 1);
    req = "R6";       run_frame(0, 40, 50, 60, 1'b1, -1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule